// File: doc/BRIEF.md
# Multi-context reservation monitor

This block keeps the load-locked / store-conditional reservations of several hardware thread contexts that share one physical memory. Each context owns a single reservation: a lock-address register and a valid flag. A locked read from a context records its physical address and sets its flag. A store-conditional is judged against the requester's own reservation. The block reports a two-bit result code and tells the memory side whether the store may be written.

Any store that really writes memory removes every reservation, in any context, that lies in the same 16-byte granule as the store. This covers an ordinary store, a successful store-conditional and an uncacheable store-conditional. Each context also keeps a count of back-to-back failed store-conditionals. A strobe fires each time that count reaches a multiple of a configurable period, so a likely livelock becomes visible.

One request is accepted on every cycle. The result, the memory write-enable and the warning strobe appear registered one cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: After reset every lock flag and every failure counter is zero, so a store-conditional that follows reset returns result 0 with no memory write.
- R2: A locked read (req_write=0, req_locked=1) sets the requester's reservation. A later cacheable store-conditional (req_write=1, req_locked=1, req_uncache=0) from the same context, to an address in the same 16-byte granule (address bits [63:4] equal), returns result 1 with rsp_mem_we=1.
- R3: The result of a cacheable store-conditional equals the requester's lock flag. If the flag is set but the granule differs, the result is 1 and rsp_mem_we is 0.
- R4: A failing store-conditional performs no memory write, clears the requester's lock flag and increments its failure counter by one.
- R5: A successful cacheable store-conditional sets the requester's failure counter to zero.
- R6: A store-conditional with req_uncache=1 returns result 2 ("do not update the destination"), writes memory, sets the requester's failure counter to zero and clears the matching reservations as in R7.
- R7: An ordinary store or a successful store-conditional clears the lock flag of every context whose lock address lies in the same 16-byte granule. Reservations in other granules are kept.
- R8: warn_strobe pulses together with the response, and warn_ctx carries the requester, on each failure that brings that context's failure count to a multiple of WARN_PERIOD.
- R9: A read, locked or not, returns result 0 with rsp_mem_we=0. An ordinary store returns result 0 with rsp_mem_we=1.
- R10: req_ready stays high, and every accepted request produces exactly one rsp_valid pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_ctx | input | CTX_W | Requesting context index |
| req_addr | input | ADDR_W | Physical address |
| req_write | input | 1 | 1 = store, 0 = read |
| req_locked | input | 1 | Locked read / conditional store |
| req_uncache | input | 1 | Address is uncacheable |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_result | output | 2 | 0 = flag clear, 1 = flag set, 2 = no update |
| rsp_mem_we | output | 1 | Memory write may proceed |
| warn_strobe | output | 1 | Failure count reached a multiple of WARN_PERIOD |
| warn_ctx | output | CTX_W | Context that raised the warning |
| fail_cnt | output | NUM_CTX*FAIL_W | Failure counters, context i at bits [i*FAIL_W +: FAIL_W] |

## Verification
The bench builds the block with four contexts, 64-bit addresses and 32-bit counters, and shrinks WARN_PERIOD to 5. With that period the warning strobe fires on the fifth and tenth failure of one context within a few dozen requests. The bench covers cross-context clearing, the flag-set-but-wrong-granule case, uncacheable store-conditionals and the failure-count resets.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      RES_CLEAR = 2'd0,
      RES_SET   = 2'd1,
      RES_NOUPD = 2'd2
   } res_t;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
   parameter int ADDR_W      = 64,
   parameter int GRAN_LSB    = 4,
   parameter int FAIL_W      = 32,
   parameter int WARN_PERIOD = 100000,
   localparam int TAG_W      = ADDR_W - GRAN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [TAG_W-1:0]  set_tag,
   input  logic              fail_inc,
   input  logic              fail_rst,
   output logic              lock_v,
   output logic [TAG_W-1:0]  lock_tag,
   output logic [FAIL_W-1:0] fails,
   output logic              warn_hit
);
   // set wins over clear: a new reservation lands after any clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_v   <= 1'b0;
         lock_tag <= '0;
      end else if (set_en) begin
         lock_v   <= 1'b1;
         lock_tag <= set_tag;
      end else if (clr_en) begin
         lock_v   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fails <= '0;
      else if (fail_rst) fails <= '0;
      else if (fail_inc) fails <= fails + 1'b1;
   end

   generate
      if (WARN_PERIOD == 0) begin : g_nowarn
         assign warn_hit = 1'b0;
      end else if (WARN_PERIOD == 1) begin : g_every
         assign warn_hit = fail_inc;
      end else begin : g_phase
         localparam int PH_W = $clog2(WARN_PERIOD);
         logic [PH_W-1:0] phase;
         assign warn_hit = fail_inc && (phase == PH_W'(WARN_PERIOD - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        phase <= '0;
            else if (fail_rst) phase <= '0;
            else if (fail_inc) phase <= warn_hit ? '0 : phase + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/resv_rsp.sv
module resv_rsp import resv_pkg::*; #(
   parameter int CTX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_d,
   input  res_t             res_d,
   input  logic             we_d,
   input  logic             warn_d,
   input  logic [CTX_W-1:0] wctx_d,
   output logic             vld_q,
   output logic [1:0]       res_q,
   output logic             we_q,
   output logic             warn_q,
   output logic [CTX_W-1:0] wctx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         res_q  <= 2'd0;
         we_q   <= 1'b0;
         warn_q <= 1'b0;
         wctx_q <= '0;
      end else begin
         vld_q  <= vld_d;
         res_q  <= res_d;
         we_q   <= vld_d & we_d;
         warn_q <= vld_d & warn_d;
         wctx_q <= wctx_d;
      end
   end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor import resv_pkg::*; #(
   parameter int NUM_CTX     = 4,
   parameter int ADDR_W      = 64,
   parameter int GRAN_LSB    = 4,
   parameter int FAIL_W      = 32,
   parameter int WARN_PERIOD = 100000,
   localparam int CTX_W      = $clog2(NUM_CTX),
   localparam int TAG_W      = ADDR_W - GRAN_LSB
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [CTX_W-1:0]          req_ctx,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_write,
   input  logic                      req_locked,
   input  logic                      req_uncache,
   output logic                      rsp_valid,
   output logic [1:0]                rsp_result,
   output logic                      rsp_mem_we,
   output logic                      warn_strobe,
   output logic [CTX_W-1:0]          warn_ctx,
   output logic [NUM_CTX*FAIL_W-1:0] fail_cnt
);
   generate
      if (NUM_CTX < 2 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
         $error("NUM_CTX must be a power of two, at least 2");
      end
      if (GRAN_LSB < 1 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
         $error("GRAN_LSB must lie in 1..ADDR_W-1");
      end
      if (FAIL_W < 2) begin : g_bad_fail
         $error("FAIL_W must be at least 2");
      end
      if (WARN_PERIOD < 0) begin : g_bad_warn
         $error("WARN_PERIOD must not be negative");
      end
   endgenerate

   logic [TAG_W-1:0]   req_tag;
   logic               unused_low;
   logic [NUM_CTX-1:0] lk_v, snoop_hit, set_en, clr_en, inc_en, rst_en, drop, warn_hit;
   logic [TAG_W-1:0]   lk_tag [NUM_CTX];
   logic               is_sc, is_st, is_ll, own_v, own_hit, store_snoop, we_d;
   res_t               res_d;

   assign req_ready  = 1'b1;
   assign req_tag    = req_addr[ADDR_W-1:GRAN_LSB];
   assign unused_low = ^req_addr[GRAN_LSB-1:0];

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      assign snoop_hit[i] = (lk_tag[i] == req_tag);
      resv_slot #(
         .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB),
         .FAIL_W(FAIL_W), .WARN_PERIOD(WARN_PERIOD)
      ) slot_i (
         .clk(clk), .rst_n(rst_n),
         .set_en(set_en[i]), .clr_en(clr_en[i]), .set_tag(req_tag),
         .fail_inc(inc_en[i]), .fail_rst(rst_en[i]),
         .lock_v(lk_v[i]), .lock_tag(lk_tag[i]),
         .fails(fail_cnt[i*FAIL_W +: FAIL_W]), .warn_hit(warn_hit[i])
      );
   end

   always_comb begin
      is_sc   = req_valid & req_write & req_locked;
      is_st   = req_valid & req_write & ~req_locked;
      is_ll   = req_valid & ~req_write & req_locked;
      own_v   = lk_v[req_ctx];
      own_hit = snoop_hit[req_ctx];
      res_d       = RES_CLEAR;
      we_d        = 1'b0;
      store_snoop = 1'b0;
      set_en      = '0;
      inc_en      = '0;
      rst_en      = '0;
      drop        = '0;
      if (is_sc && req_uncache) begin
         res_d           = RES_NOUPD;
         we_d            = 1'b1;
         store_snoop     = 1'b1;
         rst_en[req_ctx] = 1'b1;
      end else if (is_sc) begin
         res_d = own_v ? RES_SET : RES_CLEAR;
         if (own_v && own_hit) begin
            we_d            = 1'b1;
            store_snoop     = 1'b1;
            rst_en[req_ctx] = 1'b1;
         end else begin
            inc_en[req_ctx] = 1'b1;
            drop[req_ctx]   = 1'b1;
         end
      end else if (is_st) begin
         we_d        = 1'b1;
         store_snoop = 1'b1;
      end else if (is_ll) begin
         set_en[req_ctx] = 1'b1;
      end
      clr_en = drop | (store_snoop ? snoop_hit : '0);
   end

   resv_rsp #(.CTX_W(CTX_W)) rsp_i (
      .clk(clk), .rst_n(rst_n),
      .vld_d(req_valid), .res_d(res_d), .we_d(we_d),
      .warn_d(|warn_hit), .wctx_d(req_ctx),
      .vld_q(rsp_valid), .res_q(rsp_result), .we_q(rsp_mem_we),
      .warn_q(warn_strobe), .wctx_q(warn_ctx)
   );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_write,
   input logic       req_locked,
   input logic       req_uncache,
   input logic       rsp_valid,
   input logic [1:0] rsp_result,
   input logic       rsp_mem_we,
   input logic       warn_strobe
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_nc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_locked && req_uncache)
      |=> (rsp_result == 2'd2 && rsp_mem_we));
   p_code2_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && rsp_valid && rsp_result == 2'd2)
      |-> $past(req_valid && req_write && req_locked && req_uncache));
   p_store_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_locked) |=> (rsp_mem_we && rsp_result == 2'd0));
   p_read_nowe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> (!rsp_mem_we && rsp_result == 2'd0));
   p_warn_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      warn_strobe |-> (rsp_valid && !rsp_mem_we && rsp_result != 2'd2));
endmodule

bind resv_monitor resv_monitor_chk chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_locked(req_locked), .req_uncache(req_uncache), .rsp_valid(rsp_valid),
   .rsp_result(rsp_result), .rsp_mem_we(rsp_mem_we), .warn_strobe(warn_strobe)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
   localparam int NC = 4;
   localparam int AW = 64;
   localparam int FW = 32;
   localparam int WP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_locked = 1'b0, req_uncache = 1'b0;
   logic [1:0] req_ctx = '0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, rsp_valid, rsp_mem_we, warn_strobe;
   logic [1:0] rsp_result, warn_ctx;
   logic [NC*FW-1:0] fail_cnt;

   always #4 clk = ~clk;

   resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_LSB(4), .FAIL_W(FW), .WARN_PERIOD(WP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctx(req_ctx), .req_addr(req_addr), .req_write(req_write),
      .req_locked(req_locked), .req_uncache(req_uncache), .rsp_valid(rsp_valid),
      .rsp_result(rsp_result), .rsp_mem_we(rsp_mem_we), .warn_strobe(warn_strobe),
      .warn_ctx(warn_ctx), .fail_cnt(fail_cnt)
   );

   typedef struct {
      int       ctx;
      int       res;
      bit       we;
      bit       warn;
      int       fails;
      string    tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   bit          m_v [NC];
   logic [AW-1:0] m_a [NC];
   int          m_f [NC];

   task automatic chk(string tag, string what, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic send(int c, logic [AW-1:0] a, bit wr, bit lk, bit uc, string tag);
      exp_t e;
      bit snoop = 1'b0;
      e.ctx = c; e.res = 0; e.we = 1'b0; e.warn = 1'b0; e.tag = tag;
      if (wr && lk && uc) begin
         e.res = 2; e.we = 1'b1; snoop = 1'b1; m_f[c] = 0;
      end else if (wr && lk) begin
         e.res = m_v[c] ? 1 : 0;
         if (m_v[c] && (m_a[c] >> 4) == (a >> 4)) begin
            e.we = 1'b1; snoop = 1'b1; m_f[c] = 0;
         end else begin
            m_v[c] = 1'b0;
            m_f[c]++;
            if (m_f[c] % WP == 0) e.warn = 1'b1;
         end
      end else if (wr) begin
         e.we = 1'b1; snoop = 1'b1;
      end
      if (snoop)
         for (int k = 0; k < NC; k++)
            if ((m_a[k] >> 4) == (a >> 4)) m_v[k] = 1'b0;
      if (!wr && lk) begin
         m_v[c] = 1'b1; m_a[c] = a;
      end
      e.fails = m_f[c];
      @(negedge clk);
      req_valid = 1'b1; req_ctx = 2'(c); req_addr = a;
      req_write = wr; req_locked = lk; req_uncache = uc;
      q.push_back(e);
   endtask

   // monitor: compares each response against the queued expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) begin
            chk("R10", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "result", rsp_result, e.res);
            chk(e.tag, "mem_we", rsp_mem_we, e.we);
            chk(e.tag, "warn", warn_strobe, e.warn);
            if (e.warn) chk(e.tag, "warn_ctx", warn_ctx, e.ctx);
            chk(e.tag, "fail_cnt", fail_cnt[e.ctx*FW +: FW], e.fails);
            chk("R10", "ready", req_ready, 1);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NC; k++) begin m_v[k] = 1'b0; m_a[k] = '0; m_f[k] = 0; end
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", rsp_valid, 0);
      chk("R1", "fail_cnt in reset", fail_cnt, 0);
      chk("R10", "ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R4: no reservation after reset
      send(0, 64'h1000, 1, 1, 0, "R1 sc after reset");
      // R2 / R5: locked read then conditional store in the same granule
      send(0, 64'h1000, 0, 1, 0, "R9 locked read");
      send(0, 64'h100C, 1, 1, 0, "R2 R5 sc success");
      // R3 / R4: flag set, wrong granule, then flag cleared
      send(1, 64'h2000, 0, 1, 0, "R9 locked read");
      send(1, 64'h3000, 1, 1, 0, "R3 flag set wrong granule");
      send(1, 64'h2000, 1, 1, 0, "R4 flag cleared by failure");
      // R7: ordinary store clears two contexts
      send(2, 64'h4000, 0, 1, 0, "R9 locked read");
      send(3, 64'h4008, 0, 1, 0, "R9 locked read");
      send(0, 64'h400F, 1, 0, 0, "R9 plain store");
      send(2, 64'h4000, 1, 1, 0, "R7 cleared by store");
      send(3, 64'h4008, 1, 1, 0, "R7 cleared by store");
      // R7: store to a neighbouring granule keeps reservation
      send(1, 64'h5000, 0, 1, 0, "R9 locked read");
      send(2, 64'h5010, 1, 0, 0, "R9 plain store");
      send(1, 64'h5004, 1, 1, 0, "R7 other granule kept R5");
      // R7: successful sc clears another context
      send(0, 64'h6000, 0, 1, 0, "R9 locked read");
      send(1, 64'h6000, 0, 1, 0, "R9 locked read");
      send(0, 64'h6000, 1, 1, 0, "R2 sc success");
      send(1, 64'h6000, 1, 1, 0, "R7 cleared by sc");
      // R6: uncacheable sc
      send(3, 64'h7000, 0, 1, 0, "R9 locked read");
      send(2, 64'h7004, 1, 1, 1, "R6 uncacheable sc");
      send(3, 64'h7000, 1, 1, 0, "R6 cleared by uncacheable");
      // R9: plain read
      send(2, 64'h7000, 0, 0, 0, "R9 plain read");
      // R8: run of failures on context 3
      for (int k = 0; k < 12; k++) send(3, 64'h8000, 1, 1, 0, "R8 failure run");
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "queue drained", q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule